// File: doc/BRIEF.md
# Interrupt Remap Entry Validator

This block checks one incoming interrupt request against a single 128-bit remapping table entry. It confirms that the entry is present, runs the requester-id source check that the entry selects, and decodes the fields used for delivery. The entry comes from a table fetch stage outside this block. The request carries a valid strobe and a 16-bit requester-id. A global flag picks the extended or the legacy destination format.

The block returns its result one cycle after a valid request. The result is a pass or block verdict, a strobe that asks for a fault to be reported, and the decoded vector, destination, destination mode, redirection hint, trigger mode and entry mode. All outputs are registered. They change only in the cycle after a request that has its valid strobe set.

Top module: `irte_validator`

## Requirements
- R1: After a request with `req_valid` high, `res_valid` is high in the next cycle. In a cycle with no request in the previous cycle, `res_valid` is low. An active-low synchronous reset clears `res_valid` and `res_fault`.
- R2: When entry bit 0 (present) is 0, the request is blocked (`res_pass`=0).
- R3: Entry bits 83:82 give the validation type. With type 00 a present entry always passes.
- R4: With type 01, the requester-id is compared with the source field at bits 79:64, under the qualifier at bits 81:80:
  - 00 compares all 16 bits.
  - 01 compares every bit except bit 2.
  - 10 compares every bit except bits 2:1.
  - 11 compares only bits 15:3.
- R5: With type 10, the request passes only when start ≤ requester-id[15:8] ≤ end. The start bus is entry bits 79:72 and the end bus is entry bits 71:64.
- R6: Type 11 is reserved, and a present entry with this type is blocked.
- R7: A blocked request raises `res_fault` exactly when entry bit 1 (fault-disable) is 0. A request that passes never raises `res_fault`.
- R8: The qualifier bits 81:80 have no effect on the verdict unless the entry is present and the type is 01.
- R9: `res_vector` is bits 23:16. `res_dest_logical` is bit 2, `res_redir_hint` is bit 3, `res_level` is bit 4 and `res_posted` is bit 15.
- R10: With `ext_mode`=1, `res_dest_id` is bits 63:32. With `ext_mode`=0, it is bits 47:40 zero-extended to 32 bits.
- R11: The `res_*` data outputs keep their value in any cycle that follows a cycle with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_rid | input | 16 | Requester-id |
| entry | input | 128 | Remap table entry |
| ext_mode | input | 1 | 1 selects the extended 32-bit destination format |
| res_valid | output | 1 | Result valid |
| res_pass | output | 1 | 1 when the request is allowed |
| res_fault | output | 1 | Fault-report strobe |
| res_vector | output | 8 | Decoded vector |
| res_dest_id | output | 32 | Decoded destination ID |
| res_dest_logical | output | 1 | Destination mode: 1 means logical |
| res_redir_hint | output | 1 | Redirection hint |
| res_level | output | 1 | Trigger mode: 1 means level |
| res_posted | output | 1 | Entry mode: 1 means posted |

## Verification
The hardest cases sit on the masked-compare boundaries. In those cases the requester-id differs from the source field only in the bits that one qualifier ignores and another does not. The bench reaches them with a sweep. For every qualifier, it takes a fixed source value and XORs it with each single-bit mask, and also with every pattern over bits 2:0. It then repeats the whole sweep under the three other validation types, which shows that the qualifier is ignored there. The bus-range check is swept over every bus number, against ranges that include an empty range and a range of one bus.

// File: rtl/irte_validator.sv
module irte_validator #(
  parameter int RID_W = 16,
  parameter int DST_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [RID_W-1:0] req_rid,
  input  logic [127:0]     entry,
  input  logic             ext_mode,
  output logic             res_valid,
  output logic             res_pass,
  output logic             res_fault,
  output logic [7:0]       res_vector,
  output logic [DST_W-1:0] res_dest_id,
  output logic             res_dest_logical,
  output logic             res_redir_hint,
  output logic             res_level,
  output logic             res_posted
);
  localparam int BUS_W = RID_W / 2;

  logic             present, no_fault;
  logic [1:0]       vtype, qual;
  logic [RID_W-1:0] src, cmp_mask;
  logic [BUS_W-1:0] bus, bus_lo, bus_hi;
  logic             id_ok, bus_ok, src_ok, pass_c;
  logic [DST_W-1:0] dest_c;

  assign present  = entry[0];
  assign no_fault = entry[1];
  assign src      = entry[79:64];
  assign qual     = entry[81:80];
  assign vtype    = entry[83:82];

  always_comb begin
    cmp_mask = '1;
    case (qual)
      2'b01:   cmp_mask[2]   = 1'b0;
      2'b10:   cmp_mask[2:1] = 2'b00;
      2'b11:   cmp_mask[2:0] = 3'b000;
      default: ;
    endcase
  end

  assign id_ok  = ((req_rid ^ src) & cmp_mask) == '0;
  assign bus    = req_rid[RID_W-1:BUS_W];
  assign bus_lo = src[RID_W-1:BUS_W];
  assign bus_hi = src[BUS_W-1:0];
  assign bus_ok = (bus >= bus_lo) && (bus <= bus_hi);

  always_comb begin
    case (vtype)
      2'b00:   src_ok = 1'b1;
      2'b01:   src_ok = id_ok;
      2'b10:   src_ok = bus_ok;
      default: src_ok = 1'b0;
    endcase
  end

  assign pass_c = present && src_ok;
  assign dest_c = ext_mode ? DST_W'(entry[63:32]) : DST_W'(entry[47:40]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_fault <= 1'b0;
    end else begin
      res_valid <= req_valid;
      res_fault <= req_valid && !pass_c && !no_fault;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_pass         <= 1'b0;
      res_vector       <= '0;
      res_dest_id      <= '0;
      res_dest_logical <= 1'b0;
      res_redir_hint   <= 1'b0;
      res_level        <= 1'b0;
      res_posted       <= 1'b0;
    end else if (req_valid) begin
      res_pass         <= pass_c;
      res_vector       <= entry[23:16];
      res_dest_id      <= dest_c;
      res_dest_logical <= entry[2];
      res_redir_hint   <= entry[3];
      res_level        <= entry[4];
      res_posted       <= entry[15];
    end
  end

  p_valid_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  p_idle_no_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid && !res_fault);
  p_not_present_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !entry[0]) |=> !res_pass);
  p_reserved_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && entry[83:82] == 2'b11) |=> !res_pass);
  p_no_fault_on_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_pass && res_valid |-> !res_fault);
  p_fault_disable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && entry[1]) |=> !res_fault);
  p_hold_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(res_vector) && $stable(res_dest_id) && $stable(res_pass));
endmodule

// File: tb/irte_validator_tb_top.sv
module irte_validator_tb_top;
  logic         clk = 0, rst_n = 0, req_valid = 0, ext_mode = 0;
  logic [15:0]  req_rid = '0;
  logic [127:0] entry = '0;
  logic         res_valid, res_pass, res_fault;
  logic [7:0]   res_vector;
  logic [31:0]  res_dest_id;
  logic         res_dest_logical, res_redir_hint, res_level, res_posted;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  irte_validator dut_i (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_pass(logic [127:0] e, logic [15:0] rid);
    logic [15:0] s, m;
    s = e[79:64];
    if (!e[0]) return 1'b0;
    case (e[83:82])
      2'b00: return 1'b1;
      2'b01: begin
        m = 16'hffff >> 3 << 3;
        case (e[81:80])
          2'b00: m = 16'hffff;
          2'b01: m = 16'hfffb;
          2'b10: m = 16'hfff9;
          default: ;
        endcase
        return ((rid ^ s) & m) == 0;
      end
      2'b10: return (rid[15:8] >= s[15:8]) && (rid[15:8] <= s[7:0]);
      default: return 1'b0;
    endcase
  endfunction

  task automatic apply(input logic [127:0] e, input logic [15:0] rid, input logic x);
    logic p;
    @(negedge clk);
    entry = e; req_rid = rid; ext_mode = x; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    p = exp_pass(e, rid);
    chk("R1 valid", res_valid, 1);
    case (e[83:82])
      2'b00: chk("R3 pass", res_pass, p);
      2'b01: chk("R4 pass", res_pass, p);
      2'b10: chk("R5 pass", res_pass, p);
      default: chk("R6 pass", res_pass, p);
    endcase
    if (!e[0]) chk("R2 pass", res_pass, 0);
    chk("R7 fault", res_fault, !p && !e[1]);
    chk("R9 fields", {res_vector, res_dest_logical, res_redir_hint, res_level, res_posted},
        {e[23:16], e[2], e[3], e[4], e[15]});
    chk("R10 dest", res_dest_id, x ? e[63:32] : {24'h0, e[47:40]});
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [127:0] e;
    logic [7:0] v0, d0;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", res_valid, 0);
    chk("R1 reset fault", res_fault, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle", res_valid, 0);
    // R4 qualifier sweep, plus R8: same sweep under other types
    for (int t = 0; t < 4; t++)
      for (int q = 0; q < 4; q++) begin
        for (int b = 0; b < 16; b++) begin
          e = '0; e[0] = 1; e[1] = b[0]; e[83:82] = t[1:0]; e[81:80] = q[1:0];
          e[79:64] = 16'hA5C3; e[23:16] = 8'(b * 7); e[63:32] = 32'hDEAD_0000 | b;
          apply(e, 16'hA5C3 ^ (16'h1 << b), b[1]);
        end
        for (int k = 0; k < 8; k++) begin
          e = '0; e[0] = 1; e[83:82] = t[1:0]; e[81:80] = q[1:0]; e[79:64] = 16'h3C5A;
          e[4:2] = k[2:0]; e[15] = k[0];
          apply(e, 16'h3C5A ^ 16'(k), k[2]);
        end
      end
    // R8 explicit: qualifier irrelevant when type is 00
    e = '0; e[0] = 1; e[79:64] = 16'h1234; e[81:80] = 2'b00;
    apply(e, 16'h0001, 0); chk("R8 q00", res_pass, 1);
    e[81:80] = 2'b11; apply(e, 16'h0001, 0); chk("R8 q11", res_pass, 1);
    // R5 bus range sweep
    for (int r = 0; r < 4; r++)
      for (int bus = 0; bus < 256; bus++) begin
        case (r)
          0: begin v0 = 8'h10; d0 = 8'h20; end
          1: begin v0 = 8'h40; d0 = 8'h40; end
          2: begin v0 = 8'h80; d0 = 8'h7f; end
          default: begin v0 = 8'h00; d0 = 8'hff; end
        endcase
        e = '0; e[0] = 1; e[83:82] = 2'b10; e[79:64] = {v0, d0}; e[81:80] = 2'(bus);
        apply(e, {8'(bus), 8'(bus * 3)}, 1);
      end
    // R2 non-present
    for (int t = 0; t < 4; t++) begin
      e = '0; e[83:82] = t[1:0]; e[1] = t[0];
      apply(e, 16'h0, 0);
    end
    // R11 hold
    e = '0; e[0] = 1; e[23:16] = 8'h5E; e[63:32] = 32'h0102_0304;
    apply(e, 0, 1);
    @(negedge clk); entry = '1; ext_mode = 0; req_rid = 16'hffff;
    @(negedge clk);
    chk("R11 hold valid", res_valid, 0);
    chk("R11 hold vec", res_vector, 8'h5E);
    chk("R11 hold dest", res_dest_id, 32'h0102_0304);
    chk("R11 hold pass", res_pass, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule